// File: doc/BRIEF.md
# Trap Vector Address Generator

This block turns a pending trap into the address of the table entry that the core must fetch next. It holds a programmable table base register, which is forced to a 1 KB boundary. It gathers trap requests from two places: a bit-per-vector request mask, where bit `v` asks for vector `v`, and a single vector-number port used by software trap instructions. It arbitrates among the requests and registers the winning fetch address one clock later.

Two cases never use the table base. Vector 0, the reset vector, always fetches from the fixed address 0xC00000, even after software has moved the table. The debugging exception has its own request input and always goes to the fixed address 0x060000, outside the table. Vector numbers that belong to no source are reserved. Requesting one raises an illegal-vector flag, and that request never produces a fetch.

Top module: `trapvec_gen`

## Requirements
- R1: After reset, `base_rdata` reads 0xC00000.
- R2: A cycle with `base_we` high loads `base_wdata` into the base register with bits 9..0 cleared. The new value appears on `base_rdata` after that clock edge, and bits 9..0 always read zero.
- R3: A granted table vector `v` other than 0 gives `fetch_valid`=1, `fetch_vec`=v and `fetch_addr` = base + 4·v, one clock after the request cycle.
- R4: A granted vector 0 always gives `fetch_addr` = 0xC00000, whatever the base register holds.
- R5: `dbg_req` gives `fetch_valid`=1, `fetch_dbg`=1, `fetch_vec`=0 and `fetch_addr` = 0x060000.
- R6: When several requests are pending in one cycle, vector 0 wins first, then the debugging exception, then the lowest-numbered legal vector.
- R7: The legal vector numbers are 0, 2, 3, 6, 7, 11 to 26, and 30+4n and 31+4n for each timer n below 4. Any other number (for example 1, 5, 32, 44) is reserved. A request for a reserved number sets `illegal_vec` for one cycle, one clock later, and takes no part in arbitration. If no legal request remains, `fetch_valid` stays 0.
- R8: `num_valid` with `num`=v counts as a request for vector v. It is merged with `req_mask` before arbitration.
- R9: A trap requested in the same cycle as a base write uses the old base. The next trap uses the new base.
- R10: A cycle with no request leaves `fetch_valid` and `illegal_vec` low in the following cycle.
- R11: Synchronous `rst` clears `fetch_valid`, `fetch_dbg` and `illegal_vec` and restores the base, even if a request is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 24 | Base register write data (bits 9..0 ignored) |
| base_rdata | output | 24 | Current base register value |
| req_mask | input | 64 | One bit per vector number requesting a trap |
| num_valid | input | 1 | Qualifies `num` as a trap request |
| num | input | 6 | Vector number requested by software |
| dbg_req | input | 1 | Debugging exception request |
| fetch_valid | output | 1 | A fetch address is presented this cycle |
| fetch_addr | output | 24 | Address of the vector to fetch |
| fetch_vec | output | 6 | Granted vector number (0 for debug) |
| fetch_dbg | output | 1 | Grant is the debugging exception |
| illegal_vec | output | 1 | A reserved vector number was requested |

## Verification
A corrupted base register shows up in two ways: on `base_rdata` right after the edge that loaded it, and in the `fetch_addr` of the very next table trap. The reset vector and the debug grant must not move with the base, so they catch a design that wrongly adds the base. A bad priority encoder or legality map shows up one clock after the request, as a wrong `fetch_vec`, as `illegal_vec` missing or raised wrongly, or as `fetch_valid` asserted for a reserved number. Directed multi-request patterns make each ordering rule visible within a single cycle.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

  // Legal vector map: fixed exceptions, peripheral block, timer pairs.
  function automatic logic vec_is_legal(input int v, input int n_tmr);
    logic ok;
    ok = 1'b0;
    if (v == 0 || v == 2 || v == 3 || v == 6 || v == 7) ok = 1'b1;
    if (v >= 11 && v <= 26) ok = 1'b1;
    if (v >= 30 && v < 30 + 4 * n_tmr && ((v - 30) % 4) < 2) ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/trapvec_base_reg.sv
module trapvec_base_reg #(
  parameter int ADDR_W     = 24,
  parameter int ALIGN_BITS = 10,
  parameter logic [ADDR_W-1:0] RST_BASE = 24'hC00000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << ALIGN_BITS;

  always_ff @(posedge clk) begin
    if (rst)     base <= RST_BASE & KEEP;
    else if (we) base <= wdata & KEEP;
  end
endmodule

// File: rtl/trapvec_req_merge.sv
module trapvec_req_merge
  import trapvec_pkg::*;
#(
  parameter int VEC_W  = 6,
  parameter int N_TMR  = 4,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic [NUM_VEC-1:0] req_mask,
  input  logic               num_valid,
  input  logic [VEC_W-1:0]   num,
  output logic [NUM_VEC-1:0] legal_req,
  output logic               any_reserved
);
  logic [NUM_VEC-1:0] merged;
  logic [NUM_VEC-1:0] rsv;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    localparam logic IS_LEGAL = vec_is_legal(i, N_TMR);
    assign merged[i] = req_mask[i] | (num_valid && (num == VEC_W'(i)));
    if (IS_LEGAL) begin : g_legal
      assign legal_req[i] = merged[i];
      assign rsv[i]       = 1'b0;
    end else begin : g_rsv
      assign legal_req[i] = 1'b0;
      assign rsv[i]       = merged[i];
    end
  end

  assign any_reserved = |rsv;
endmodule

// File: rtl/trapvec_pick.sv
module trapvec_pick #(
  parameter int VEC_W = 6,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic [NUM_VEC-1:0] req,
  output logic               found,
  output logic [VEC_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/trapvec_gen.sv
module trapvec_gen #(
  parameter int ADDR_W     = 24,
  parameter int VEC_W      = 6,
  parameter int ALIGN_BITS = 10,
  parameter int N_TMR      = 4,
  parameter logic [ADDR_W-1:0] RST_BASE = 24'hC00000,
  parameter logic [ADDR_W-1:0] RST_ADDR = 24'hC00000,
  parameter logic [ADDR_W-1:0] DBG_ADDR = 24'h060000,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               base_we,
  input  logic [ADDR_W-1:0]  base_wdata,
  output logic [ADDR_W-1:0]  base_rdata,
  input  logic [NUM_VEC-1:0] req_mask,
  input  logic               num_valid,
  input  logic [VEC_W-1:0]   num,
  input  logic               dbg_req,
  output logic               fetch_valid,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [VEC_W-1:0]   fetch_vec,
  output logic               fetch_dbg,
  output logic               illegal_vec
);
  logic [NUM_VEC-1:0] legal_req;
  logic               any_rsv;
  logic               found;
  logic [VEC_W-1:0]   win;
  logic [ADDR_W-1:0]  entry_addr;
  logic               nxt_valid, nxt_dbg;
  logic [ADDR_W-1:0]  nxt_addr;
  logic [VEC_W-1:0]   nxt_vec;

  trapvec_base_reg #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .RST_BASE(RST_BASE)
  ) base_i (
    .clk(clk), .rst(rst), .we(base_we), .wdata(base_wdata), .base(base_rdata)
  );

  trapvec_req_merge #(.VEC_W(VEC_W), .N_TMR(N_TMR)) merge_i (
    .req_mask(req_mask), .num_valid(num_valid), .num(num),
    .legal_req(legal_req), .any_reserved(any_rsv)
  );

  trapvec_pick #(.VEC_W(VEC_W)) pick_i (
    .req(legal_req), .found(found), .idx(win)
  );

  // Entry offset is vector * 4; base register value before this edge.
  assign entry_addr = base_rdata + ADDR_W'({win, 2'b00});

  always_comb begin
    nxt_valid = found | dbg_req;
    nxt_dbg   = 1'b0;
    nxt_vec   = '0;
    nxt_addr  = '0;
    if (found && win == '0) begin
      nxt_addr = RST_ADDR;
    end else if (dbg_req) begin
      nxt_dbg  = 1'b1;
      nxt_addr = DBG_ADDR;
    end else if (found) begin
      nxt_vec  = win;
      nxt_addr = entry_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_valid <= 1'b0;
      fetch_dbg   <= 1'b0;
      fetch_vec   <= '0;
      fetch_addr  <= '0;
      illegal_vec <= 1'b0;
    end else begin
      fetch_valid <= nxt_valid;
      fetch_dbg   <= nxt_dbg;
      fetch_vec   <= nxt_vec;
      fetch_addr  <= nxt_addr;
      illegal_vec <= any_rsv;
    end
  end
endmodule

// File: rtl/trapvec_gen_chk.sv
module trapvec_gen_chk
  import trapvec_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int VEC_W      = 6,
  parameter int ALIGN_BITS = 10,
  parameter int N_TMR      = 4,
  parameter logic [ADDR_W-1:0] RST_ADDR = 24'hC00000,
  parameter logic [ADDR_W-1:0] DBG_ADDR = 24'h060000,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input logic               clk,
  input logic               rst,
  input logic               base_we,
  input logic [ADDR_W-1:0]  base_wdata,
  input logic [ADDR_W-1:0]  base_rdata,
  input logic [NUM_VEC-1:0] req_mask,
  input logic               num_valid,
  input logic               dbg_req,
  input logic               fetch_valid,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic [VEC_W-1:0]   fetch_vec,
  input logic               fetch_dbg,
  input logic               illegal_vec
);
  localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << ALIGN_BITS;

  assert_base_align_R2: assert property (@(posedge clk) disable iff (rst)
    (base_rdata & ~KEEP) == '0);

  assert_base_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(base_we)) |-> base_rdata == ($past(base_wdata) & KEEP));

  assert_entry_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_dbg && fetch_vec != '0)
      |-> fetch_addr == $past(base_rdata) + ADDR_W'({fetch_vec, 2'b00}));

  assert_reset_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_dbg && fetch_vec == '0) |-> fetch_addr == RST_ADDR);

  assert_dbg_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_dbg |-> (fetch_valid && fetch_vec == '0 && fetch_addr == DBG_ADDR));

  assert_legal_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_dbg) |-> vec_is_legal(int'(fetch_vec), N_TMR));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_mask) == '0 && !$past(num_valid) && !$past(dbg_req))
      |-> (!fetch_valid && !illegal_vec));
endmodule

bind trapvec_gen trapvec_gen_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .ALIGN_BITS(ALIGN_BITS), .N_TMR(N_TMR),
  .RST_ADDR(RST_ADDR), .DBG_ADDR(DBG_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
  .base_rdata(base_rdata), .req_mask(req_mask), .num_valid(num_valid),
  .dbg_req(dbg_req), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .fetch_vec(fetch_vec), .fetch_dbg(fetch_dbg), .illegal_vec(illegal_vec)
);

// File: tb/trapvec_gen_tb_top.sv
`timescale 1ns/1ps
module trapvec_gen_tb_top;
  localparam int AW = 24;
  localparam int VW = 6;
  localparam int NV = 1 << VW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          base_we = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic [AW-1:0] base_rdata;
  logic [NV-1:0] req_mask = '0;
  logic          num_valid = 1'b0;
  logic [VW-1:0] num = '0;
  logic          dbg_req = 1'b0;
  logic          fetch_valid, fetch_dbg, illegal_vec;
  logic [AW-1:0] fetch_addr;
  logic [VW-1:0] fetch_vec;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trapvec_gen dut_i (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .base_rdata(base_rdata), .req_mask(req_mask), .num_valid(num_valid),
    .num(num), .dbg_req(dbg_req), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_vec(fetch_vec), .fetch_dbg(fetch_dbg),
    .illegal_vec(illegal_vec)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one request cycle at the falling edge, clear after the rising edge.
  task automatic fire(input logic [NV-1:0] m, input logic nv, input logic [VW-1:0] n,
                      input logic d);
    @(negedge clk);
    req_mask = m; num_valid = nv; num = n; dbg_req = d;
    @(posedge clk); #2;
    req_mask = '0; num_valid = 1'b0; num = '0; dbg_req = 1'b0; base_we = 1'b0;
  endtask

  task automatic write_base(input logic [AW-1:0] v);
    @(negedge clk);
    base_we = 1'b1; base_wdata = v;
    @(posedge clk); #2;
    base_we = 1'b0;
  endtask

  function automatic logic [NV-1:0] bit_of(input int v);
    return NV'(1) << v;
  endfunction

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
    check("R1", "base after reset", 64'(base_rdata), 64'hC00000);
    check("R11", "fetch_valid after reset", 64'(fetch_valid), 0);
    check("R11", "illegal after reset", 64'(illegal_vec), 0);
  endtask

  task automatic t_base_write;
    write_base(24'h123FFF);
    check("R2", "low bits cleared", 64'(base_rdata), 64'h123C00);
    write_base(24'h4003FF);
    check("R2", "aligned write", 64'(base_rdata), 64'h400000);
  endtask

  task automatic t_vectors;
    int list[11] = '{2, 3, 6, 7, 11, 15, 16, 26, 30, 31, 43};
    write_base(24'h400000);
    foreach (list[k]) begin
      fire(bit_of(list[k]), 1'b0, '0, 1'b0);
      check("R3", $sformatf("addr vec %0d", list[k]), 64'(fetch_addr),
            64'h400000 + 64'(4 * list[k]));
      check("R3", $sformatf("vec %0d", list[k]), 64'(fetch_vec), 64'(list[k]));
      check("R7", $sformatf("legal %0d valid", list[k]), 64'(fetch_valid), 1);
    end
  endtask

  task automatic t_reset_vec;
    write_base(24'h801400);
    fire(bit_of(0), 1'b0, '0, 1'b0);
    check("R4", "reset vector fixed", 64'(fetch_addr), 64'hC00000);
    check("R4", "reset vector valid", 64'(fetch_valid), 1);
  endtask

  task automatic t_debug;
    fire('0, 1'b0, '0, 1'b1);
    check("R5", "debug addr", 64'(fetch_addr), 64'h060000);
    check("R5", "debug flag", 64'(fetch_dbg), 1);
    fire(bit_of(7) | bit_of(2), 1'b0, '0, 1'b1);
    check("R6", "debug beats vector 2", 64'(fetch_addr), 64'h060000);
    fire(bit_of(0), 1'b0, '0, 1'b1);
    check("R6", "reset beats debug addr", 64'(fetch_addr), 64'hC00000);
    check("R6", "reset beats debug flag", 64'(fetch_dbg), 0);
  endtask

  task automatic t_priority;
    write_base(24'h200000);
    fire(bit_of(7) | bit_of(12) | bit_of(20), 1'b0, '0, 1'b0);
    check("R6", "lowest of 7,12,20", 64'(fetch_vec), 7);
    fire(bit_of(22) | bit_of(31), 1'b0, '0, 1'b0);
    check("R6", "lowest of 22,31 addr", 64'(fetch_addr), 64'h200058);
  endtask

  task automatic t_reserved;
    fire(bit_of(1), 1'b0, '0, 1'b0);
    check("R7", "vec1 no fetch", 64'(fetch_valid), 0);
    check("R7", "vec1 illegal", 64'(illegal_vec), 1);
    fire(bit_of(5) | bit_of(16), 1'b0, '0, 1'b0);
    check("R7", "reserved 5 skipped", 64'(fetch_vec), 16);
    check("R7", "reserved 5 flagged", 64'(illegal_vec), 1);
    fire(bit_of(32), 1'b0, '0, 1'b0);
    check("R7", "timer gap 32", 64'({fetch_valid, illegal_vec}), 1);
    fire('0, 1'b1, 6'd44, 1'b0);
    check("R7", "num 44 reserved", 64'({fetch_valid, illegal_vec}), 1);
  endtask

  task automatic t_num;
    fire('0, 1'b1, 6'd13, 1'b0);
    check("R8", "num 13 addr", 64'(fetch_addr), 64'h200034);
    check("R8", "num 13 illegal clear", 64'(illegal_vec), 0);
    fire(bit_of(25), 1'b1, 6'd20, 1'b0);
    check("R8", "num 20 vs mask 25", 64'(fetch_vec), 20);
  endtask

  task automatic t_write_same;
    @(negedge clk);
    base_we = 1'b1; base_wdata = 24'h500000; req_mask = bit_of(3);
    @(posedge clk); #2;
    base_we = 1'b0; req_mask = '0;
    check("R9", "trap uses old base", 64'(fetch_addr), 64'h20000C);
    check("R9", "base updated", 64'(base_rdata), 64'h500000);
    fire(bit_of(3), 1'b0, '0, 1'b0);
    check("R9", "next trap new base", 64'(fetch_addr), 64'h50000C);
  endtask

  task automatic t_idle;
    fire('0, 1'b0, '0, 1'b0);
    check("R10", "idle no fetch", 64'(fetch_valid), 0);
    check("R10", "idle no illegal", 64'(illegal_vec), 0);
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    rst = 1'b1; req_mask = bit_of(1) | bit_of(11); dbg_req = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0; req_mask = '0; dbg_req = 1'b0;
    check("R11", "reset over request", 64'({fetch_valid, fetch_dbg, illegal_vec}), 0);
    check("R11", "base restored", 64'(base_rdata), 64'hC00000);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_base_write();
    t_vectors();
    t_reset_vec();
    t_debug();
    t_priority();
    t_reserved();
    t_num();
    t_write_same();
    t_idle();
    t_mid_reset();
    finished = 1;
    summary();
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
    end
  end
endmodule